// File: doc/BRIEF.md
# Base-and-Bounds Address Relocator

This block turns the addresses that a processor issues for the running program into physical addresses. Each program is linked as though it begins at address zero, so every incoming address is an offset from that program's own origin. The relocator adds a base value to the offset to form the physical address. It compares that sum with the end of the program's region, which is the base plus a length value. An address that lands beyond the region, or that carries past the top of the address space, is flagged as a fault.

Software loads the base and length through a plain register write port whenever it switches to another program. Requests arrive on a valid/ready stream that carries an offset and an access strobe. Results leave on a second valid/ready stream that carries the physical address, a fault flag and the forwarded strobe, one cycle after the request is accepted. A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the result is held unchanged and no new request is taken.

Top module: `addr_reloc`

## Requirements
- R1: A non-faulting result gives `rsp_paddr` equal to base plus `req_vaddr`, truncated to ADDR_W bits.
- R2: `rsp_fault` is 1 when base plus the offset is greater than base plus length, with both sums taken at ADDR_W+1 bits. An offset equal to the length does not fault.
- R3: `rsp_fault` is 1 when base plus the offset carries out of ADDR_W bits, even if the region limit itself also carries.
- R4: When `rsp_fault` is 1, `rsp_paddr` is 0 and `rsp_strobe` is 0. Otherwise `rsp_strobe` equals the `req_strobe` of that request.
- R5: A register write takes effect for requests accepted after the write edge. A request accepted on the same edge as a write is translated with the old values.
- R6: A request accepted on one clock edge yields `rsp_valid` high after that edge, so the latency is one cycle.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0 and `rsp_paddr`, `rsp_fault` and `rsp_strobe` stay stable. Request inputs offered during that time are not taken.
- R8: Reset clears base and length to 0 and `rsp_valid` to 0. After reset, offset 0 translates to 0 without fault and offset 1 faults.
- R9: `cfg_sel` = 0 writes the base and `cfg_sel` = 1 writes the length. A write to one register leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 1 | Register select: 0 base, 1 length |
| cfg_wdata | input | ADDR_W | Register write data |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_vaddr | input | ADDR_W | Program-relative address |
| req_strobe | input | 1 | Memory access strobe of the request |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | ADDR_W | Physical address, 0 on fault |
| rsp_fault | output | 1 | Bounds or wrap fault |
| rsp_strobe | output | 1 | Forwarded access strobe, 0 on fault |

## Verification
The assertions check four properties on every cycle. A faulting result carries a zero address and no strobe. Every accepted request produces a result. A stalled result stays stable while the input is refused. A non-faulting translation never lies below the base. Only the bench can show the arithmetic itself. It does this with an exhaustive sweep of base, length and offset at a 4-bit width, where the faults at the region edge and on carry-out are compared with expected values worked out in the bench. The bench also covers the old-value rule for a write that lands in the same cycle as a request, and the selection of one register without disturbing the other.

// File: rtl/addr_reloc_pkg.sv
package addr_reloc_pkg;
  typedef enum logic {
    REG_BASE = 1'b0,
    REG_LEN  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/addr_reloc_regs.sv
module addr_reloc_regs
  import addr_reloc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] len_q
);
  reg_sel_e target;
  assign target = reg_sel_e'(sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
    end else if (we) begin
      if (target == REG_BASE) base_q <= wdata;
      else                    len_q  <= wdata;
    end
  end

  // R9
  len_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && target == REG_BASE) |=> $stable(len_q));
endmodule

// File: rtl/addr_reloc_xlate.sv
module addr_reloc_xlate #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] len,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              strobe_in,
  output logic [ADDR_W-1:0] paddr,
  output logic              fault,
  output logic              strobe_out
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] phys_ext;
  logic [EXT_W-1:0] limit_ext;
  logic             wrapped;
  logic             past_end;

  assign phys_ext  = {1'b0, base} + {1'b0, vaddr};
  assign limit_ext = {1'b0, base} + {1'b0, len};
  assign wrapped   = phys_ext[ADDR_W];
  assign past_end  = phys_ext > limit_ext;
  assign fault     = wrapped | past_end;
  assign paddr     = fault ? '0 : phys_ext[ADDR_W-1:0];
  assign strobe_out = strobe_in & ~fault;
endmodule

// File: rtl/addr_reloc_rsp.sv
module addr_reloc_rsp #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_paddr,
  input  logic              in_fault,
  input  logic              in_strobe,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_paddr,
  output logic              out_fault,
  output logic              out_strobe
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_paddr  <= '0;
      out_fault  <= 1'b0;
      out_strobe <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_paddr  <= in_paddr;
        out_fault  <= in_fault;
        out_strobe <= in_strobe;
      end
    end
  end

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_paddr)
      && $stable(out_fault) && $stable(out_strobe)));

  // R4
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fault) |-> (out_paddr == '0 && !out_strobe));
endmodule

// File: rtl/addr_reloc.sv
module addr_reloc #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_strobe,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic              rsp_strobe
);
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] len_q;
  logic [ADDR_W-1:0] x_paddr;
  logic              x_fault;
  logic              x_strobe;

  addr_reloc_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .base_q(base_q), .len_q(len_q)
  );

  addr_reloc_xlate #(.ADDR_W(ADDR_W)) xlate_i (
    .base(base_q), .len(len_q), .vaddr(req_vaddr), .strobe_in(req_strobe),
    .paddr(x_paddr), .fault(x_fault), .strobe_out(x_strobe)
  );

  addr_reloc_rsp #(.ADDR_W(ADDR_W)) rsp_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_paddr(x_paddr), .in_fault(x_fault), .in_strobe(x_strobe),
    .out_valid(rsp_valid), .out_ready(rsp_ready),
    .out_paddr(rsp_paddr), .out_fault(rsp_fault), .out_strobe(rsp_strobe)
  );

  // R1
  above_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !x_fault) |-> (x_paddr >= base_q));

  // R7
  stall_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: tb/addr_reloc_tb_top.sv
`timescale 1ns/1ps
module addr_reloc_tb_top;
  localparam int W = 4;
  localparam int TOP = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic         cfg_sel = 1'b0;
  logic [W-1:0] cfg_wdata = '0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [W-1:0] req_vaddr = '0;
  logic         req_strobe = 1'b0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [W-1:0] rsp_paddr;
  logic         rsp_fault;
  logic         rsp_strobe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_reloc #(.ADDR_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_strobe(req_strobe), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_strobe(rsp_strobe)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = W'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one request, checked one cycle later against bench arithmetic
  task automatic access(input int b, input int l, input int v, input bit s,
                        input string tag);
    int phys, lim, exp_pa;
    bit exp_f;
    phys = b + v;
    lim  = b + l;
    exp_f = (phys > TOP) || (phys > lim);
    exp_pa = exp_f ? 0 : phys;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = W'(v); req_strobe = s;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R6 valid"}, int'(rsp_valid), 1);
    check({tag, " R1 paddr"}, int'(rsp_paddr), exp_pa);
    check({tag, " R2 R3 fault"}, int'(rsp_fault), int'(exp_f));
    check({tag, " R4 strobe"}, int'(rsp_strobe), int'(s && !exp_f));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8 rsp_valid", int'(rsp_valid), 0);
    check("R8 req_ready", int'(req_ready), 1);
    access(0, 0, 0, 1'b1, "R8 zero");
    access(0, 0, 1, 1'b1, "R8 one");

    // exhaustive sweep: R1 R2 R3 R4
    for (int b = 0; b <= TOP; b++) begin
      for (int l = 0; l <= TOP; l++) begin
        wr(1'b0, b);
        wr(1'b1, l);
        for (int v = 0; v <= TOP; v++) access(b, l, v, v[0], "sweep");
      end
    end

    // R5 write in the same cycle as a request uses old base
    wr(1'b0, 3);
    wr(1'b1, 5);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = W'(8);
    req_valid = 1'b1; req_vaddr = W'(2); req_strobe = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R5 old base", int'(rsp_paddr), 5);
    access(8, 5, 2, 1'b1, "R5 new base");

    // R9 length write keeps base
    wr(1'b1, 1);
    access(8, 1, 1, 1'b1, "R9 base kept");
    access(8, 1, 2, 1'b1, "R9 length used");

    // R7 back-pressure
    wr(1'b1, 5);
    wr(1'b0, 3);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_vaddr = W'(2); req_strobe = 1'b1;
    @(negedge clk);
    check("R7 ready low", int'(req_ready), 0);
    req_vaddr = W'(4);
    @(negedge clk);
    @(negedge clk);
    check("R7 held valid", int'(rsp_valid), 1);
    check("R7 held paddr", int'(rsp_paddr), 5);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 next paddr", int'(rsp_paddr), 7);
    @(negedge clk);
    check("R7 drained", int'(rsp_valid), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule